// File: doc/BRIEF.md
# Streaming Accelerator Host Shell

This block wraps a small streaming processing chain so that host software can run it through a simple memory-mapped register and buffer window. The host fills an on-chip input buffer and sets a word count and a gain. It then writes the start bit and polls a status word until the run has finished. After that it reads the results out of an on-chip output buffer. Inside the shell, a reader walks the input buffer and feeds a registered gain stage. A writer collects the scaled words into the output buffer. All stages pass words over valid/ready handshakes.

The chain reports events by setting sticky bits in an event word. The host polls that word and clears bits by writing ones to them. The gain is copied when a run starts, so the host can prepare the gain for the next run while the current run is still in progress. Blocks longer than the buffer are processed by software in several runs.

Top module: `accel_shell`

## Requirements
- R1: After reset, the status word reads 0, the event word reads 0, the length word reads 0 and the gain word reads 0x0100 (unity).
- R2: A read strobe returns its data on `bus_rdata` in the cycle after the strobe. Byte address 0x08 holds the length, 0x0C the gain, 0x10 the events, 0x04 the status, and 0x00 (control) reads as 0.
- R3: Each output word equals the input word times the signed gain, shifted right arithmetically by 8 (rounding toward minus infinity), then clamped to the signed 16-bit range.
- R4: Status bit 1 (done) sets once the last output word of a run has been written, and status bit 0 (busy) clears at the same time. Busy and done are never both set.
- R5: A write of 1 to control bit 0 starts a run and clears done. A control write with bit 0 at 0 has no effect.
- R6: A gain write during a run does not change that run's output. It takes effect from the next run on.
- R7: Event bit 0 is set when an output word saturates. It stays set until the host writes 1 to bit 0 of the event word. Writing 0 there leaves it set.
- R8: A start with length 0 sets done in the next cycle without going busy, and it sets event bit 1.
- R9: A length larger than the buffer depth (16 words) is clamped to the depth, so every buffer word is processed and the run still completes.
- R10: A start written while busy is ignored, and the running run keeps its word count.
- R11: The input buffer starts at byte address 0x400 and the output buffer at 0x800, one word per 4 bytes. The host can write and read the input buffer and can read the output buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the read strobe |

## Verification
A stuck or mis-sequenced run state shows at the status word: done never rises, or it rises a few cycles too soon while output words are still stale. A poll within about twenty cycles of the start exposes this. A wrong latched gain or a bad saturation step shows as wrong output-buffer words as soon as the run completes, and the sticky event bit shows a missed or spurious saturation on the next read of the event word. A counter that skips, overruns or restarts leaves a word at the end of the buffer holding a value from an earlier run, and the first readback after done reveals it.

// File: rtl/accel_pkg.sv
package accel_pkg;
  localparam int DATA_W = 16;
  localparam int FRAC_W = 8;
  localparam int PROD_W = 2 * DATA_W;

  typedef struct packed {
    logic signed [DATA_W-1:0] val;
    logic                     sat;
  } scaled_t;

  // Fixed-point scale with saturation to the signed data range.
  function automatic scaled_t scale_sat(input logic signed [DATA_W-1:0] d,
                                        input logic signed [DATA_W-1:0] g);
    logic signed [PROD_W-1:0] p;
    logic signed [PROD_W-1:0] s;
    logic signed [PROD_W-1:0] hi;
    logic signed [PROD_W-1:0] lo;
    scaled_t r;
    p  = PROD_W'(d) * PROD_W'(g);
    s  = p >>> FRAC_W;
    hi = PROD_W'((1 << (DATA_W-1)) - 1);
    lo = -hi - 1;
    if (s > hi) begin
      r.val = hi[DATA_W-1:0];
      r.sat = 1'b1;
    end else if (s < lo) begin
      r.val = lo[DATA_W-1:0];
      r.sat = 1'b1;
    end else begin
      r.val = s[DATA_W-1:0];
      r.sat = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/accel_src.sv
module accel_src #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic [CNT_W-1:0] run_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CNT_W-1:0] rd_idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_idx <= '0;
    else if (start) rd_idx <= '0;
    else if (out_valid && out_ready) rd_idx <= rd_idx + 1'b1;
  end

  assign out_valid = busy && (rd_idx < run_len);
endmodule

// File: rtl/accel_gain.sv
module accel_gain
  import accel_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic signed [DATA_W-1:0] gain,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_data,
  output logic                     sat_hit
);
  scaled_t res;
  logic    accept;

  assign res      = scale_sat(in_data, gain);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign sat_hit  = accept && res.sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= res.val;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/accel_sink.sv
module accel_sink #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] run_len,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_cnt,
  output logic             last_wr
);
  assign in_ready = 1'b1;
  assign wr_en    = in_valid;
  assign last_wr  = wr_en && (wr_cnt == run_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_cnt <= '0;
    else if (start) wr_cnt <= '0;
    else if (wr_en) wr_cnt <= wr_cnt + 1'b1;
  end
endmodule

// File: rtl/accel_shell.sv
module accel_shell
  import accel_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [1:0] RG_REG = 2'd0;
  localparam logic [1:0] RG_IN  = 2'd1;
  localparam logic [1:0] RG_OUT = 2'd2;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_LEN  = 3'd2;
  localparam logic [2:0] A_GAIN = 3'd3;
  localparam logic [2:0] A_EVT  = 3'd4;
  localparam logic signed [DATA_W-1:0] UNITY = DATA_W'(1 << FRAC_W);

  logic signed [DATA_W-1:0] in_mem  [DEPTH];
  logic signed [DATA_W-1:0] out_mem [DEPTH];

  logic [1:0]        region;
  logic [2:0]        reg_sel;
  logic [IDX_W-1:0]  word_idx;
  logic              reg_wr;
  logic              ctrl_go;
  logic              start;
  logic [CNT_W-1:0]  len_clamp;

  logic [LEN_W-1:0]         len_q;
  logic signed [DATA_W-1:0] gain_q;
  logic signed [DATA_W-1:0] run_gain;
  logic [CNT_W-1:0]         run_len;
  logic                     busy;
  logic                     done;
  logic [1:0]               ev;
  logic [1:0]               ev_clr;

  logic             src_valid, src_ready;
  logic [CNT_W-1:0] rd_idx;
  logic             g_valid, g_ready, sat_hit;
  logic signed [DATA_W-1:0] g_data;
  logic             out_wr, last_wr;
  logic [CNT_W-1:0] wr_cnt;

  assign region    = bus_addr[ADDR_W-1:ADDR_W-2];
  assign reg_sel   = bus_addr[4:2];
  assign word_idx  = bus_addr[IDX_W+1:2];
  assign reg_wr    = bus_wr && (region == RG_REG);
  assign ctrl_go   = reg_wr && (reg_sel == A_CTRL) && bus_wdata[0];
  assign start     = ctrl_go && !busy;
  assign len_clamp = (len_q > LEN_W'(DEPTH)) ? CNT_W'(DEPTH) : len_q[CNT_W-1:0];
  assign ev_clr    = (reg_wr && (reg_sel == A_EVT)) ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      gain_q   <= UNITY;
      run_gain <= UNITY;
      run_len  <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      ev       <= '0;
    end else begin
      if (reg_wr && reg_sel == A_LEN)  len_q  <= bus_wdata[LEN_W-1:0];
      if (reg_wr && reg_sel == A_GAIN) gain_q <= bus_wdata[DATA_W-1:0];
      if (start) begin
        run_gain <= gain_q;
        run_len  <= len_clamp;
        busy     <= (len_clamp != '0);
        done     <= (len_clamp == '0);
      end else if (last_wr) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
      // set wins over a clear in the same cycle
      ev[0] <= sat_hit || (ev[0] && !ev_clr[0]);
      ev[1] <= (start && len_clamp == '0) || (ev[1] && !ev_clr[1]);
    end
  end

  always_ff @(posedge clk) begin
    if (bus_wr && region == RG_IN) in_mem[word_idx] <= bus_wdata[DATA_W-1:0];
    if (out_wr) out_mem[wr_cnt[IDX_W-1:0]] <= g_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      unique case (region)
        RG_IN:   bus_rdata <= BUS_W'(in_mem[word_idx]);
        RG_OUT:  bus_rdata <= BUS_W'(out_mem[word_idx]);
        RG_REG: begin
          case (reg_sel)
            A_STAT:  bus_rdata <= BUS_W'({done, busy});
            A_LEN:   bus_rdata <= BUS_W'(len_q);
            A_GAIN:  bus_rdata <= BUS_W'(gain_q);
            A_EVT:   bus_rdata <= BUS_W'(ev);
            default: bus_rdata <= '0;
          endcase
        end
        default: bus_rdata <= '0;
      endcase
    end
  end

  accel_src #(.CNT_W(CNT_W)) u_src (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .run_len(run_len),
    .out_valid(src_valid), .out_ready(src_ready), .rd_idx(rd_idx)
  );

  accel_gain u_gain (
    .clk(clk), .rst_n(rst_n), .in_valid(src_valid), .in_ready(src_ready),
    .in_data(in_mem[rd_idx[IDX_W-1:0]]), .gain(run_gain),
    .out_valid(g_valid), .out_ready(g_ready), .out_data(g_data), .sat_hit(sat_hit)
  );

  accel_sink #(.CNT_W(CNT_W)) u_sink (
    .clk(clk), .rst_n(rst_n), .start(start), .run_len(run_len),
    .in_valid(g_valid), .in_ready(g_ready), .wr_en(out_wr),
    .wr_cnt(wr_cnt), .last_wr(last_wr)
  );
endmodule

// File: rtl/accel_shell_chk.sv
module accel_shell_chk #(
  parameter int CNT_W  = 5,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ctrl_go,
  input logic [CNT_W-1:0]  len_clamp,
  input logic [CNT_W-1:0]  run_len,
  input logic [DATA_W-1:0] run_gain,
  input logic              busy,
  input logic              done,
  input logic [1:0]        ev,
  input logic [1:0]        ev_clr,
  input logic              out_wr,
  input logic [CNT_W-1:0]  wr_cnt
);
  // R4
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R5
  start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && len_clamp != '0 |=> busy && !done);
  // R8
  empty_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && len_clamp == '0 |=> done && !busy && ev[1]);
  // R6
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(run_gain));
  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctrl_go |=> $stable(run_len) && busy);
  // R7
  sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev[0] && !ev_clr[0] |=> ev[0]);
  // R9
  out_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> (wr_cnt < run_len) && (run_len <= CNT_W'(DEPTH)));
endmodule

bind accel_shell accel_shell_chk #(.CNT_W(CNT_W), .DATA_W(accel_pkg::DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ctrl_go(ctrl_go),
  .len_clamp(len_clamp), .run_len(run_len), .run_gain(run_gain),
  .busy(busy), .done(done), .ev(ev), .ev_clr(ev_clr),
  .out_wr(out_wr), .wr_cnt(wr_cnt)
);

// File: tb/sim_accel_shell.sv
`timescale 1ns/1ps
module sim_accel_shell;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int n_chk = 0, n_fail = 0;
  logic signed [15:0] stim [16];

  always #4 clk = ~clk;

  accel_shell u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
                  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // Model: floor(d*g/256), clamped to the signed 16-bit range.
  function automatic logic [31:0] model(input int d, input int g);
    longint p, q;
    p = longint'(d) * longint'(g);
    if (p >= 0) q = p / 256;
    else q = -((-p + 255) / 256);
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return 32'(signed'(16'(q)));
  endfunction

  task automatic wait_done(input string req);
    logic [31:0] s;
    int k = 0;
    do begin
      rd(12'h004, s);
      k++;
    end while (s[1] == 1'b0 && k < 200);
    check(req, s, 32'h2);
  endtask

  task automatic load_in(input int n);
    for (int i = 0; i < n; i++) wr(12'h400 + 12'(4*i), 32'(stim[i]));
  endtask

  task automatic check_out(input string req, input int n, input int g);
    logic [31:0] v;
    for (int i = 0; i < n; i++) begin
      rd(12'h800 + 12'(4*i), v);
      check(req, v, model(int'(stim[i]), g));
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(12'h004, v); check("R1 status", v, 32'h0);
    rd(12'h010, v); check("R1 events", v, 32'h0);
    rd(12'h008, v); check("R1 length", v, 32'h0);
    rd(12'h00C, v); check("R1 gain", v, 32'h100);
    rd(12'h000, v); check("R2 ctrl reads 0", v, 32'h0);
  endtask

  task automatic t_regs_and_buffer;
    logic [31:0] v;
    wr(12'h008, 32'd5); rd(12'h008, v); check("R2 length", v, 32'd5);
    wr(12'h00C, 32'h0180); rd(12'h00C, v); check("R2 gain", v, 32'h180);
    wr(12'h404, 32'h0000_1234); rd(12'h404, v); check("R11 in buffer", v, 32'h1234);
  endtask

  task automatic t_basic;
    for (int i = 0; i < 16; i++) stim[i] = 16'(i * 300 - 2000);
    load_in(16);
    wr(12'h008, 32'd16); wr(12'h00C, 32'h0100); wr(12'h000, 32'h1);
    wait_done("R4 done unity");
    check_out("R3 unity", 16, 256);
    wr(12'h00C, 32'h0280); wr(12'h000, 32'h1);
    wait_done("R4 done gain2.5");
    check_out("R3 gain 2.5", 16, 640);
    wr(12'h00C, 32'hFF40); wr(12'h000, 32'h1);
    wait_done("R4 done neg gain");
    check_out("R3 negative gain", 16, -192);
  endtask

  task automatic t_ctrl_zero;
    logic [31:0] v;
    wr(12'h000, 32'h0);
    rd(12'h004, v); check("R5 ctrl bit0=0 no start", v, 32'h2);
  endtask

  task automatic t_gain_change;
    wr(12'h00C, 32'h0100); wr(12'h008, 32'd16);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h1;
    @(negedge clk); bus_addr = 12'h00C; bus_wdata = 32'h0200;
    @(negedge clk); bus_wr = 1'b0;
    wait_done("R6 done");
    check_out("R6 old gain kept", 16, 256);
    wr(12'h000, 32'h1);
    wait_done("R6 done next");
    check_out("R6 new gain next run", 16, 512);
  endtask

  task automatic t_busy_start;
    wr(12'h00C, 32'h0000); wr(12'h008, 32'd8); wr(12'h000, 32'h1);
    wait_done("R10 prep");
    wr(12'h00C, 32'h0100);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h1;
    @(negedge clk); bus_addr = 12'h008; bus_wdata = 32'd2;
    @(negedge clk); bus_addr = 12'h000; bus_wdata = 32'h1;
    @(negedge clk); bus_wr = 1'b0;
    wait_done("R10 done");
    check_out("R10 full run kept", 8, 256);
  endtask

  task automatic t_sat;
    logic [31:0] v;
    stim[0] = 16'sh4000; stim[1] = -16'sh4000; stim[2] = 16'sd100;
    load_in(3);
    wr(12'h00C, 32'h0400); wr(12'h008, 32'd3); wr(12'h000, 32'h1);
    wait_done("R7 done");
    check_out("R3 saturation", 3, 1024);
    rd(12'h010, v); check("R7 event set", v, 32'h1);
    wr(12'h010, 32'h0);
    rd(12'h010, v); check("R7 write 0 keeps", v, 32'h1);
    wr(12'h010, 32'h1);
    rd(12'h010, v); check("R7 write 1 clears", v, 32'h0);
  endtask

  task automatic t_empty;
    logic [31:0] v;
    wr(12'h008, 32'd0); wr(12'h000, 32'h1);
    rd(12'h004, v); check("R8 done at once", v, 32'h2);
    rd(12'h010, v); check("R8 empty event", v, 32'h2);
    wr(12'h010, 32'h2);
  endtask

  task automatic t_clamp;
    for (int i = 0; i < 16; i++) stim[i] = 16'(1000 - i * 77);
    load_in(16);
    wr(12'h00C, 32'h0000); wr(12'h008, 32'd16); wr(12'h000, 32'h1);
    wait_done("R9 prep");
    wr(12'h00C, 32'h0300); wr(12'h008, 32'd40); wr(12'h000, 32'h1);
    wait_done("R9 done clamped");
    check_out("R9 all words", 16, 768);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs_and_buffer;
    t_basic;
    t_ctrl_zero;
    t_gain_change;
    t_busy_start;
    t_sat;
    t_empty;
    t_clamp;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule